// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block keeps a small first-in, first-out store of instruction bytes filled ahead of the execution side. It keeps its own 16-bit fetch offset and forms a 20-bit code address from it by shifting the code segment value left by four bits and adding the offset. Whenever the store has room and the execution side is not holding the bus, it raises a single-byte read request on a request/acknowledge memory port. Each accepted byte is appended to the store.

The execution side reads the head byte from a show-ahead output and pops it with a one-cycle strobe. When a control transfer happens, a flush strobe empties the store and reloads the fetch offset in the same cycle. A fetch that is still outstanding at that moment runs to completion on the memory port, but its byte is thrown away.

Top module: `prefetch_queue`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `empty_o` is 1 and `mem_req_o` is 0. The fetch offset resets to 0.
- R2: Bytes appear on `pop_data_o` in the order their fetches were accepted. `pop_data_o` shows the oldest byte whenever `empty_o` is 0, and a pop strobe at a clock edge removes it.
- R3: The queue never holds more than 6 bytes. A new request is raised only when the bytes stored plus the one outstanding request, if any, total less than 6.
- R4: A new request is never raised at an edge where `bus_busy_i` was 1. A request already raised is not affected by `bus_busy_i`.
- R5: `mem_addr_o` equals (`cs_base_i` × 16 + offset) modulo 2^20, taken when the request is raised.
- R6: The fetch offset grows by one for each accepted byte and wraps from 0xFFFF to 0x0000.
- R7: A flush at an edge leaves the queue empty after that edge and loads `flush_off_i` as the next fetch offset. A pop or an acknowledge in the same cycle has no effect on the queue.
- R8: If a request is outstanding when a flush occurs, its acknowledged byte is discarded and the offset is not advanced.
- R9: A pop while `empty_o` is 1 is ignored. The queue stays empty unless a byte is accepted at the same edge.
- R10: Once raised, `mem_req_o` stays 1 and `mem_addr_o` stays stable until an edge where `mem_ack_i` is 1. Only one request is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_base_i | input | 16 | Code segment value |
| flush_i | input | 1 | Empty the queue and reload the fetch offset |
| flush_off_i | input | 16 | New fetch offset, used on flush |
| bus_busy_i | input | 1 | Execution side is using the bus; no new fetch starts |
| mem_req_o | output | 1 | Fetch request |
| mem_addr_o | output | 20 | Fetch byte address |
| mem_ack_i | input | 1 | Memory acknowledge; data valid |
| mem_data_i | input | 8 | Fetched byte |
| pop_i | input | 1 | Remove the head byte |
| pop_data_o | output | 8 | Head byte (show-ahead) |
| empty_o | output | 1 | Queue holds no bytes |

## Verification
Several rules are checked by assertions on every cycle: a held request keeps its address until it is acknowledged, no fetch starts while the bus is busy or the queue lacks room, the queue is empty after a flush, and an ignored pop leaves it empty. Other behaviour can only be shown by the bench's scenarios against its reference model. This covers byte ordering through interleaved pops and fills, the composed 20-bit address including both the 16-bit offset wrap and the 20-bit sum wrap, and the discarding of a byte whose request straddled a flush.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam int unsigned OFF_W   = 16;
  localparam int unsigned SEG_W   = 16;
  localparam int unsigned SHIFT_W = 4;
  localparam int unsigned ADDR_W  = SEG_W + SHIFT_W;

  function automatic logic [ADDR_W-1:0] phys_addr(input logic [SEG_W-1:0] seg,
                                                  input logic [OFF_W-1:0] off);
    phys_addr = {seg, {SHIFT_W{1'b0}}} + ADDR_W'(off);
  endfunction
endpackage

// File: rtl/pfq_store.sv
module pfq_store #(
  parameter int unsigned DEPTH = 6,
  parameter int unsigned DW    = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [DW-1:0]    push_data_i,
  input  logic             pop_i,
  output logic [DW-1:0]    head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             empty_o
);
  logic [DW-1:0]    slot_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_en, pop_en;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    nxt = (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign push_en = push_i && !clr_i;
  assign pop_en  = pop_i && !empty_o && !clr_i;
  assign head_o  = slot_q[rd_q];
  assign count_o = cnt_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  slot_q[g] <= '0;
      else if (push_en && (wr_q == PTR_W'(g)))      slot_q[g] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_en) wr_q <= nxt(wr_q);
      if (pop_en)  rd_q <= nxt(rd_q);
      case ({push_en, pop_en})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_en && !pop_en) |-> (cnt_q < CNT_W'(DEPTH))); // R3
  AST_EMPTY_POP_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o); // R9
endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch
  import pfq_pkg::*;
#(
  parameter int unsigned DEPTH   = 6,
  parameter logic [OFF_W-1:0] RST_OFF = '0,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEG_W-1:0]  cs_base_i,
  input  logic              flush_i,
  input  logic [OFF_W-1:0]  flush_off_i,
  input  logic              bus_busy_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              mem_ack_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              accept_o
);
  logic [OFF_W-1:0]  off_q;
  logic [ADDR_W-1:0] addr_q;
  logic              pend_q, drop_q;
  logic              issue, ack_fire;

  // one request in flight, so "room" is count below depth
  assign issue    = !pend_q && !bus_busy_i && !flush_i && (count_i < CNT_W'(DEPTH));
  assign ack_fire = pend_q && mem_ack_i;
  assign accept_o = ack_fire && !drop_q && !flush_i;

  assign mem_req_o  = pend_q;
  assign mem_addr_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q  <= RST_OFF;
      addr_q <= '0;
      pend_q <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      if (flush_i)       off_q <= flush_off_i;
      else if (accept_o) off_q <= off_q + 1'b1;

      if (issue) begin
        pend_q <= 1'b1;
        addr_q <= phys_addr(cs_base_i, off_q);
      end else if (ack_fire) begin
        pend_q <= 1'b0;
      end

      // stale response still owed by memory after a flush
      if (ack_fire)              drop_q <= 1'b0;
      else if (flush_i && pend_q) drop_q <= 1'b1;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o))); // R10
  AST_ISSUE_IDLE_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> !$past(bus_busy_i)); // R4
  AST_ISSUE_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> ($past(count_i) < CNT_W'(DEPTH))); // R3
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
  import pfq_pkg::*;
#(
  parameter int unsigned DEPTH = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       cs_base_i,
  input  logic              flush_i,
  input  logic [15:0]       flush_off_i,
  input  logic              bus_busy_i,
  output logic              mem_req_o,
  output logic [19:0]       mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [7:0]        mem_data_i,
  input  logic              pop_i,
  output logic [7:0]        pop_data_o,
  output logic              empty_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] count;
  logic             accept;

  pfq_fetch #(.DEPTH(DEPTH)) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_base_i   (cs_base_i),
    .flush_i     (flush_i),
    .flush_off_i (flush_off_i),
    .bus_busy_i  (bus_busy_i),
    .count_i     (count),
    .mem_ack_i   (mem_ack_i),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .accept_o    (accept)
  );

  pfq_store #(.DEPTH(DEPTH), .DW(8)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (flush_i),
    .push_i      (accept),
    .push_data_i (mem_data_i),
    .pop_i       (pop_i),
    .head_o      (pop_data_o),
    .count_o     (count),
    .empty_o     (empty_o)
  );

  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o); // R7
endmodule

// File: tb/prefetch_queue_tb_top.sv
module prefetch_queue_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cs_base = 16'h1234;
  logic        flush = 1'b0;
  logic [15:0] flush_off = '0;
  logic        busy = 1'b1;
  logic        req;
  logic [19:0] addr;
  logic        ack = 1'b0;
  logic [7:0]  rdata = '0;
  logic        pop = 1'b0;
  logic [7:0]  pdata;
  logic        empty;

  always #10 clk = ~clk;

  prefetch_queue dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_base_i(cs_base), .flush_i(flush),
    .flush_off_i(flush_off), .bus_busy_i(busy), .mem_req_o(req),
    .mem_addr_o(addr), .mem_ack_i(ack), .mem_data_i(rdata), .pop_i(pop),
    .pop_data_o(pdata), .empty_o(empty)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0]  mq[$];
  logic [15:0] exp_off = '0;
  logic [15:0] cs_v = 16'h1234;
  bit          tainted = 0;
  bit          prev_req = 0, prev_busy = 1, prev_ack = 0;
  logic [19:0] prev_addr = '0;
  int p_flush = 0, p_pop = 0, p_busy = 100, p_ack = 0;

  function automatic logic [7:0] mem_byte(input logic [19:0] a);
    return a[7:0] ^ {a[19:16], a[11:8]} ^ 8'h5A;
  endfunction

  function automatic logic [19:0] exp_addr(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycle(input bit f_force, input logic [15:0] f_off, input logic [15:0] f_cs);
    bit fl, pp, bz, ak, accepted;
    logic [15:0] foff, ncs;
    @(negedge clk);
    chk(empty == (mq.size() == 0), "R2 R7 R8 R9 empty", 32'(empty), 32'(mq.size() == 0));
    if (req && !tainted) begin
      chk(addr == exp_addr(cs_v, exp_off), "R5 R6 address", 32'(addr), 32'(exp_addr(cs_v, exp_off)));
      chk(mq.size() < 6, "R3 room", 32'(mq.size()), 32'd5);
    end
    if (req && !prev_req) chk(!prev_busy, "R4 issue while busy", 32'(prev_busy), 32'd0);
    if (prev_req && !prev_ack)
      chk(req && addr == prev_addr, "R10 hold", {11'd0, req, addr}, {12'h001, prev_addr});

    fl   = f_force || (($urandom % 100) < p_flush);
    foff = f_force ? f_off : 16'($urandom);
    ncs  = f_force ? f_cs : 16'($urandom);
    pp   = ($urandom % 100) < p_pop;
    bz   = ($urandom % 100) < p_busy;
    ak   = req && (($urandom % 100) < p_ack);

    if (pp && mq.size() > 0 && !fl) begin
      chk(pdata == mq[0], "R2 order", 32'(pdata), 32'(mq[0]));
      void'(mq.pop_front());
    end
    if (ak) begin
      accepted = !tainted && !fl;
      if (accepted) begin
        chk(mq.size() < 6, "R3 overflow", 32'(mq.size()), 32'd5);
        mq.push_back(mem_byte(addr));
        exp_off = exp_off + 16'd1;
      end
      tainted = 0;
    end
    if (fl) begin
      mq.delete();
      exp_off = foff;
      cs_v    = ncs;
      if (req && !ak) tainted = 1;
    end

    flush = fl; flush_off = foff; cs_base = cs_v; pop = pp; busy = bz;
    ack = ak; rdata = ak ? mem_byte(addr) : 8'h00;
    prev_req = req; prev_busy = bz; prev_ack = ak; prev_addr = addr;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle(0, '0, '0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd7));
    repeat (2) begin
      @(negedge clk);
      chk(empty == 1'b1, "R1 empty in reset", 32'(empty), 32'd1);
      chk(req == 1'b0, "R1 no request in reset", 32'(req), 32'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(empty && !req, "R1 after reset", {30'd0, empty, req}, 32'd2);
    prev_busy = 1;

    // pops on empty, bus busy: nothing may move
    p_busy = 100; p_pop = 100; p_ack = 0;
    run(10);
    chk(!req, "R4 busy held", 32'(req), 32'd0);
    chk(empty, "R9 empty pops", 32'(empty), 32'd1);

    // fill to capacity with no pops
    p_busy = 0; p_pop = 0; p_ack = 100;
    run(20);
    chk(mq.size() == 6, "R3 model full", 32'(mq.size()), 32'd6);
    @(negedge clk);
    chk(!req && !empty, "R3 full stops fetch", {30'd0, req, empty}, 32'd0);

    // drain in order
    p_pop = 100; p_ack = 0;
    run(10);

    // offset and address wrap
    p_pop = 0; p_ack = 100;
    cycle(1, 16'hFFFE, 16'hFFFF);
    run(12);
    chk(exp_off == 16'h0004, "R6 wrap model", 32'(exp_off), 32'h4);

    // flush with a request in flight
    p_pop = 30; p_ack = 0;
    cycle(1, 16'h0100, 16'h2000);
    run(3);
    cycle(1, 16'h0200, 16'h3000);
    chk(tainted, "R8 straddle set up", 32'(tainted), 32'd1);
    p_ack = 100;
    run(10);

    // flush and pop together on a non-empty queue
    p_pop = 100;
    cycle(1, 16'h0400, 16'h0040);
    run(5);

    // random traffic
    p_flush = 3; p_pop = 40; p_busy = 25; p_ack = 50;
    run(3000);

    summary();
  end
endmodule